// File: doc/BRIEF.md
# Clock Reference Selector with Alarms

This block chooses the timing reference for a network clock unit. Up to six external candidates can feed it: two clock supply routes and four digital trunk routes. Each candidate is counted against the local oscillator over a fixed window. A route whose edge count falls outside the expected band is marked failed. It is marked healthy again only after two good windows in a row. The block drives a mux select and the flags that tell the phase-locked loop whether to track, to hold its last phase or to run free. It also drives major, minor and sync status lines for the alarm panel.

In subordinate operation, the healthy enabled route with the highest priority is chosen, and switching back to a restored route is revertive. In source operation, the internal oscillator is always chosen and the external routes are ignored.

Top module: `clock_ref_selector`

## Requirements
- R1: With `sub_mode` low (source operation), `ref_sel` is 6 (internal oscillator), `freerun` is 1, and `holdover`, `in_sync` and `alarm_minor` are 0, whatever the route inputs do.
- R2: `route_en` bit k enables route k, with bit 0 = clock supply route 0, bit 1 = clock supply route 1, and bits 2..5 = trunk routes 0..3. A disabled route is never selected and never raises `alarm_minor`.
- R3: In subordinate operation the selected route is the healthy enabled route with the lowest bit index, and `ref_sel` equals that index (0..5). The supply routes therefore win over the trunks, route 0 wins over route 1, and trunk 0 wins over trunk 3.
- R4: `trunk_rate[k]` sets the nominal rate of trunk k: 1 means the 2.048 MHz count (EXP_FAST per window) and 0 means the 1.544 MHz count (EXP_SLOW). Supply routes expect EXP_DCS.
- R5: A route is marked failed at the end of any window in which its rising-edge count lies outside expected ± TOL.
- R6: A failed route becomes healthy only at the end of its second consecutive good window. A restored higher-priority route is then reselected.
- R7: In subordinate operation with no healthy enabled route, `hold_strap` = 1 gives `ref_sel` 7 with `holdover` 1. `hold_strap` = 0 gives `ref_sel` 6 with `freerun` 1.
- R8: `alarm_minor` is 1 in subordinate operation when at least one enabled route has failed while at least one enabled route is healthy.
- R9: `alarm_major` is 1 in subordinate operation when no enabled route is healthy, including the case where no route is enabled. In source operation it follows `osc_bad`.
- R10: `in_sync` is 1 only in subordinate operation while a healthy external route is selected.
- R11: All outputs are registered. `ref_sel` changes on a single clock edge per switch. It changes only one cycle after a window boundary or one cycle after a change of mode, enables or strap.
- R12: While `rst_n` is low, `ref_sel` is 6 and every flag and alarm output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Active-low reset |
| sub_mode | input | 1 | 1 = subordinate operation, 0 = source operation |
| route_en | input | 6 | Per-route enable |
| trunk_rate | input | 4 | Per-trunk nominal rate, 1 = 2.048 MHz |
| hold_strap | input | 1 | Action when every route has failed: 1 = holdover, 0 = free-run |
| osc_bad | input | 1 | Internal oscillator out of tolerance |
| ref_in | input | 6 | Candidate reference clocks, asynchronous |
| ref_sel | output | 3 | Mux select: 0..5 route, 6 internal, 7 holdover |
| holdover | output | 1 | Holding last phase |
| freerun | output | 1 | Internal oscillator in use |
| alarm_major | output | 1 | Major alarm |
| alarm_minor | output | 1 | Minor alarm |
| in_sync | output | 1 | Locked to a healthy external route |

## Verification
A health bit stuck in the wrong state shows up at the ports within one or two measurement windows. It appears as the wrong `ref_sel` index, or as a minor alarm that fails to set or to clear. A broken consecutive-window count makes a route return one window early, which the bench sees by checking `ref_sel` exactly one window after restoration. A wrong rate or limit compare makes a correctly clocked trunk fail, or lets a mis-rated one pass, one window after the stimulus.

// File: rtl/clock_ref_selector.sv
module clock_ref_selector #(
  parameter int WIN      = 192,
  parameter int EXP_DCS  = 16,
  parameter int EXP_SLOW = 12,
  parameter int EXP_FAST = 16,
  parameter int TOL      = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_mode,
  input  logic [5:0] route_en,
  input  logic [3:0] trunk_rate,
  input  logic       hold_strap,
  input  logic       osc_bad,
  input  logic [5:0] ref_in,
  output logic [2:0] ref_sel,
  output logic       holdover,
  output logic       freerun,
  output logic       alarm_major,
  output logic       alarm_minor,
  output logic       in_sync
);
  localparam int NR = 6;
  localparam int CW = $clog2(WIN + 1);
  localparam int WW = $clog2(WIN);
  localparam logic [2:0] SEL_INT  = 3'd6;
  localparam logic [2:0] SEL_HOLD = 3'd7;

  logic [WW-1:0] win_cnt;
  logic          win_end;
  logic [NR-1:0] s1, s2, s3, rise, healthy, usable;

  assign win_end = (win_cnt == WW'(WIN - 1));
  assign rise    = s2 & ~s3;
  assign usable  = route_en & healthy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      win_cnt <= '0;
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      win_cnt <= win_end ? '0 : win_cnt + 1'b1;
      s1 <= ref_in; s2 <= s1; s3 <= s2;
    end

  for (genvar i = 0; i < NR; i++) begin : g_mon
    logic [CW-1:0] cnt, total;
    logic          good_prev, h;
    int            expv;
    logic          in_band;

    if (i < 2) begin : g_dcs
      assign expv = EXP_DCS;
    end else begin : g_trk
      assign expv = trunk_rate[i-2] ? EXP_FAST : EXP_SLOW;
    end

    assign total   = cnt + CW'(rise[i]);
    assign in_band = (int'(total) >= expv - TOL) && (int'(total) <= expv + TOL);
    assign healthy[i] = h;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0; good_prev <= 1'b0; h <= 1'b0;
      end else if (win_end) begin
        cnt       <= '0;
        good_prev <= in_band;
        h         <= in_band & (good_prev | h);
      end else begin
        cnt <= total;
      end
  end

  logic [2:0] pick, sel_n;
  logic       ho_n, fr_n, maj_n, min_n, syn_n;

  always_comb begin
    pick = '0;
    for (int k = NR - 1; k >= 0; k--)
      if (usable[k]) pick = 3'(k);
  end

  always_comb begin
    sel_n = SEL_INT; ho_n = 1'b0; fr_n = 1'b0; syn_n = 1'b0;
    if (!sub_mode) fr_n = 1'b1;
    else if (|usable) begin
      sel_n = pick; syn_n = 1'b1;
    end else if (hold_strap) begin
      sel_n = SEL_HOLD; ho_n = 1'b1;
    end else fr_n = 1'b1;
  end

  assign maj_n = sub_mode ? ~|usable : osc_bad;
  assign min_n = sub_mode & (|(route_en & ~healthy)) & (|usable);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_sel <= SEL_INT; holdover <= 1'b0; freerun <= 1'b0;
      alarm_major <= 1'b0; alarm_minor <= 1'b0; in_sync <= 1'b0;
    end else begin
      ref_sel <= sel_n; holdover <= ho_n; freerun <= fr_n;
      alarm_major <= maj_n; alarm_minor <= min_n; in_sync <= syn_n;
    end
endmodule

// File: rtl/clock_ref_selector_chk.sv
module clock_ref_selector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sub_mode,
  input logic [5:0] route_en,
  input logic       hold_strap,
  input logic [2:0] ref_sel,
  input logic       holdover,
  input logic       freerun,
  input logic       alarm_major,
  input logic       alarm_minor,
  input logic       in_sync,
  input logic       win_end
);
  logic [5:0] en_q;
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= '0; age <= '0;
    end else begin
      en_q <= route_en;
      if (age != 2'd3) age <= age + 1'b1;
    end

  p_src_internal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_mode |=> (ref_sel == 3'd6 && freerun && !in_sync && !alarm_minor));

  p_disabled_unused_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sel < 3'd6) |-> en_q[ref_sel]);

  p_hold_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    holdover |-> (ref_sel == 3'd7 && !freerun && alarm_major));

  p_alarm_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(alarm_major && alarm_minor));

  p_sync_ext_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync |-> (ref_sel < 3'd6 && !holdover && !freerun && !alarm_major));

  p_sel_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !$past(win_end, 2) && $past($stable(sub_mode))
     && $past($stable(route_en)) && $past($stable(hold_strap))) |-> $stable(ref_sel));
endmodule

bind clock_ref_selector clock_ref_selector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sub_mode(sub_mode), .route_en(route_en),
  .hold_strap(hold_strap), .ref_sel(ref_sel), .holdover(holdover),
  .freerun(freerun), .alarm_major(alarm_major), .alarm_minor(alarm_minor),
  .in_sync(in_sync), .win_end(win_end)
);

// File: tb/test_clock_ref_selector.sv
module test_clock_ref_selector;
  localparam int WIN = 192;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sub_mode = 1'b1, hold_strap = 1'b1, osc_bad = 1'b0;
  logic [5:0] route_en = 6'h3F;
  logic [3:0] trunk_rate = 4'h0;
  logic [5:0] ref_in;
  logic [2:0] ref_sel;
  logic holdover, freerun, alarm_major, alarm_minor, in_sync;
  int per [6] = '{12, 12, 16, 16, 16, 16};
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  for (genvar g = 0; g < 6; g++) begin : gen_src
    logic s = 1'b0;
    always begin
      if (per[g] < 2) begin s = 1'b0; @(negedge clk); end
      else begin repeat (per[g] / 2) @(negedge clk); s = ~s; end
    end
    assign ref_in[g] = s;
  end

  clock_ref_selector i_clock_ref_selector (
    .clk(clk), .rst_n(rst_n), .sub_mode(sub_mode), .route_en(route_en),
    .trunk_rate(trunk_rate), .hold_strap(hold_strap), .osc_bad(osc_bad),
    .ref_in(ref_in), .ref_sel(ref_sel), .holdover(holdover), .freerun(freerun),
    .alarm_major(alarm_major), .alarm_minor(alarm_minor), .in_sync(in_sync));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_win(input int n);
    repeat (n * WIN) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R12 sel", ref_sel, 6);
    chk("R12 major", alarm_major, 0);
    chk("R12 sync", in_sync, 0);
    chk("R12 freerun", freerun, 0);
    rst_n = 1'b1;
    wait_win(4);
  endtask

  task automatic t_all_good;
    chk("R3 sel dcs0", ref_sel, 0);
    chk("R10 sync", in_sync, 1);
    chk("R8 minor clear", alarm_minor, 0);
    chk("R9 major clear", alarm_major, 0);
  endtask

  task automatic t_supply_fail;
    per[0] = 0; wait_win(2);
    chk("R5 sel dcs1", ref_sel, 1);
    chk("R8 minor set", alarm_minor, 1);
    per[1] = 0; wait_win(2);
    chk("R3 trunk fallback", ref_sel, 2);
  endtask

  task automatic t_enable;
    route_en[2] = 1'b0; repeat (3) @(negedge clk);
    chk("R2 disabled skip", ref_sel, 3);
    route_en[1:0] = 2'b00; repeat (3) @(negedge clk);
    chk("R2 disabled no alarm", alarm_minor, 0);
    route_en = 6'h3F; repeat (3) @(negedge clk);
    chk("R3 trunk0 again", ref_sel, 2);
  endtask

  task automatic t_rate;
    per[2] = 12; wait_win(2);
    chk("R4 wrong rate fails", ref_sel, 3);
    trunk_rate[0] = 1'b1; wait_win(4);
    chk("R4 fast rate accepted", ref_sel, 2);
  endtask

  task automatic t_all_fail;
    for (int k = 0; k < 6; k++) per[k] = 0;
    wait_win(2);
    chk("R7 hold sel", ref_sel, 7);
    chk("R7 hold flag", holdover, 1);
    chk("R9 major all failed", alarm_major, 1);
    chk("R8 minor none healthy", alarm_minor, 0);
    chk("R10 sync off", in_sync, 0);
    hold_strap = 1'b0; repeat (3) @(negedge clk);
    chk("R7 freerun sel", ref_sel, 6);
    chk("R7 freerun flag", freerun, 1);
    chk("R7 hold cleared", holdover, 0);
  endtask

  task automatic t_restore;
    per[0] = 12; wait_win(1);
    chk("R6 not after one window", ref_sel, 6);
    wait_win(3);
    chk("R6 restored", ref_sel, 0);
    chk("R8 minor others failed", alarm_minor, 1);
    chk("R9 major cleared", alarm_major, 0);
  endtask

  task automatic t_revert;
    int changes = 0;
    logic [2:0] last;
    per[1] = 12; wait_win(4);
    per[0] = 0; wait_win(2);
    chk("R3 dcs1 backup", ref_sel, 1);
    per[0] = 12;
    last = ref_sel;
    for (int c = 0; c < 5 * WIN; c++) begin
      @(negedge clk);
      if (ref_sel != last) changes++;
      last = ref_sel;
    end
    chk("R11 single switch", changes, 1);
    chk("R6 revertive", ref_sel, 0);
  endtask

  task automatic t_source;
    per[0] = 0; sub_mode = 1'b0; repeat (3) @(negedge clk);
    chk("R1 sel internal", ref_sel, 6);
    chk("R1 freerun", freerun, 1);
    chk("R1 sync off", in_sync, 0);
    wait_win(2);
    chk("R1 no minor", alarm_minor, 0);
    chk("R9 osc ok", alarm_major, 0);
    osc_bad = 1'b1; repeat (3) @(negedge clk);
    chk("R9 osc bad", alarm_major, 1);
    osc_bad = 1'b0;
  endtask

  task automatic t_none_enabled;
    sub_mode = 1'b1; route_en = 6'h00; repeat (3) @(negedge clk);
    chk("R9 none enabled major", alarm_major, 1);
    chk("R2 none enabled sel", ref_sel, 6);
  endtask

  initial begin
    fork
      begin
        t_reset; t_all_good; t_supply_fail; t_enable; t_rate;
        t_all_fail; t_restore; t_revert; t_source; t_none_enabled;
      end
      begin
        repeat (150000) @(negedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual 1 expected 0");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule